// File: doc/BRIEF.md
# Instruction Predecoder and Cycle Estimator

This block looks at a single 16-bit instruction word and sorts it into one of four encoding classes: arithmetic, memory, short branch and miscellaneous. It reports whether a 16-bit immediate word follows, which sets the instruction length. The fetch stage uses that length to advance, and the conditional-skip path uses it to step over a whole instruction.

From the current word-addressed program counter, the block also produces:
- the relative branch target;
- the address of the next instruction;
- a flag for instructions that push a return address;
- the number of cycles the instruction costs.

The cycle count is a sum of fixed penalties on top of a base cost. A skip-taken input adds the cost of a failed condition. The block is purely combinational and does not execute anything.

Top module: `insn_predecode`

## Requirements
- R1: The class output `fmt_o` is 0 when bit 15 is 0 (arithmetic), 1 when bits 15:14 are 10 (memory), 2 when bits 15:13 are 110 (short branch) and 3 when bits 15:13 are 111 (miscellaneous).
- R2: `imm_o` is 1 in exactly these cases, and `len_o` is then 2 (otherwise 1):
  - an arithmetic word whose operand field, bits 5:0, equals 0x10;
  - a memory word whose mode field, bits 7:0, lies in 0x10..0x2e;
  - a miscellaneous word whose opcode, bits 12:8, equals 1.
- R3: For a short branch, `target_o` equals `pc_i` plus bits 11:0 sign-extended to 16 bits, modulo 2^16.
- R4: `next_pc_o` equals `target_o` for a short branch, and `pc_i + len_o` for every other class.
- R5: `push_o` is 1 for a short branch with bit 12 set, and for a miscellaneous word with opcode 0 or 1. It is 0 for all other words.
- R6: `cycles_o` starts at a base of 1, plus 1 when an immediate follows.
- R7: An arithmetic word with opcode (bits 14:10) 0x0e or 0x0f adds 1 cycle. Opcode 0x10 or 0x11 adds 31 cycles. Opcode 0x12 or 0x13 adds 15 cycles.
- R8: A jump adds 1 cycle. Jumps are:
  - every short branch;
  - miscellaneous opcodes 0 and 1;
  - an arithmetic non-compare word whose destination (bits 9:6) is 15;
  - a memory load (opcode bits 13:12 equal 0 or 2) whose register (bits 11:8) is 15.
- R9: A memory access adds 1 cycle. Memory accesses are:
  - every memory-class word;
  - every push per R5;
  - miscellaneous opcodes 2 and 3.
- R10: For an arithmetic compare (opcode 0x16..0x1f), `skip_i` = 1 adds 1 cycle. For any other word, `skip_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word under inspection |
| pc_i | input | 16 | Word address of that instruction |
| skip_i | input | 1 | Condition of a compare evaluated false |
| fmt_o | output | 2 | Encoding class (0 arith, 1 memory, 2 branch, 3 misc) |
| imm_o | output | 1 | A 16-bit immediate word follows |
| len_o | output | 2 | Instruction length in words |
| target_o | output | 16 | Relative branch destination |
| next_pc_o | output | 16 | Address of the following instruction |
| push_o | output | 1 | Instruction pushes a return address |
| cycles_o | output | 6 | Estimated cycle cost |

## Verification
Several cost terms can apply to the same word, and these collisions are the main risk. Examples:
- an immediate with a divide and a jump to r15, costing 34 cycles;
- a load into r15 with a post-update immediate;
- a compare with an immediate operand while `skip_i` is high.

Directed words place the largest sums and the boundary modes 0x0f, 0x10, 0x2e and 0x2f on the inputs. Random words with random `skip_i` cover the remaining overlaps. Every output is compared against a reference function that rebuilds each penalty from the requirement text.

// File: rtl/insn_predecode.sv
module insn_predecode #(
  parameter int W = 16
) (
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] pc_i,
  input  logic         skip_i,
  output logic [1:0]   fmt_o,
  output logic         imm_o,
  output logic [1:0]   len_o,
  output logic [W-1:0] target_o,
  output logic [W-1:0] next_pc_o,
  output logic         push_o,
  output logic [5:0]   cycles_o
);
  localparam int DISP_W = 12;

  wire       is_ar = ~instr_i[15];
  wire       is_ls = instr_i[15:14] == 2'b10;
  wire       is_br = instr_i[15:13] == 3'b110;
  wire       is_mi = instr_i[15:13] == 3'b111;

  wire [4:0] ar_op = instr_i[14:10];
  wire [3:0] ar_a  = instr_i[9:6];
  wire [5:0] ar_b  = instr_i[5:0];
  wire [1:0] ls_op = instr_i[13:12];
  wire [3:0] ls_a  = instr_i[11:8];
  wire [7:0] ls_m  = instr_i[7:0];
  wire [4:0] mi_op = instr_i[12:8];

  wire ar_cmp = is_ar && ar_op >= 5'h16;

  assign fmt_o = is_ar ? 2'd0 : is_ls ? 2'd1 : is_br ? 2'd2 : 2'd3;

  assign imm_o = (is_ar && ar_b == 6'h10) ||
                 (is_ls && ls_m >= 8'h10 && ls_m <= 8'h2e) ||
                 (is_mi && mi_op == 5'd1);
  assign len_o = imm_o ? 2'd2 : 2'd1;

  assign target_o  = pc_i + {{(W-DISP_W){instr_i[DISP_W-1]}}, instr_i[DISP_W-1:0]};
  assign next_pc_o = is_br ? target_o : pc_i + W'(len_o);

  assign push_o = (is_br && instr_i[12]) || (is_mi && mi_op <= 5'd1);

  wire jump = is_br || (is_mi && mi_op <= 5'd1) ||
              (is_ar && !ar_cmp && ar_a == 4'hf) ||
              (is_ls && !ls_op[0] && ls_a == 4'hf);
  wire mem  = is_ls || push_o || (is_mi && (mi_op == 5'd2 || mi_op == 5'd3));

  logic [5:0] op_pen;
  always_comb begin
    op_pen = 6'd0;
    if (is_ar) begin
      case (ar_op)
        5'h0e, 5'h0f: op_pen = 6'd1;
        5'h10, 5'h11: op_pen = 6'd31;
        5'h12, 5'h13: op_pen = 6'd15;
        default:      op_pen = 6'd0;
      endcase
    end
  end

  assign cycles_o = 6'd1 + 6'(imm_o) + op_pen + 6'(jump) + 6'(mem) +
                    6'(ar_cmp && skip_i);
endmodule

module insn_predecode_chk (
  input logic [15:0] instr_i,
  input logic [15:0] pc_i,
  input logic        skip_i,
  input logic [1:0]  fmt_o,
  input logic        imm_o,
  input logic [1:0]  len_o,
  input logic [15:0] target_o,
  input logic [15:0] next_pc_o,
  input logic        push_o,
  input logic [5:0]  cycles_o
);
  always_comb begin
    p_len_imm_r2: assert (len_o == (imm_o ? 2'd2 : 2'd1));
    p_branch_next_r4: assert (fmt_o != 2'd2 || next_pc_o == target_o);
    p_branch_noimm_r2: assert (fmt_o != 2'd2 || !imm_o);
    p_push_class_r5: assert (!push_o || fmt_o[1]);
    p_cost_range_r6: assert (cycles_o >= 6'd1 && cycles_o <= 6'd34);
    p_mem_cost_r9: assert (fmt_o != 2'd1 || cycles_o >= 6'd2);
    p_push_cost_r8: assert (!push_o || cycles_o >= 6'd3);
  end
endmodule

bind insn_predecode insn_predecode_chk chk_i (.*);

// File: tb/insn_predecode_tb.sv
module insn_predecode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] instr, pc;
  logic        skip;
  logic [1:0]  fmt, len;
  logic        imm, push;
  logic [15:0] target, next_pc;
  logic [5:0]  cycles;

  int checks = 0, errors = 0;

  insn_predecode dut_i (
    .instr_i(instr), .pc_i(pc), .skip_i(skip),
    .fmt_o(fmt), .imm_o(imm), .len_o(len), .target_o(target),
    .next_pc_o(next_pc), .push_o(push), .cycles_o(cycles)
  );

  function automatic logic [1:0] ref_fmt(input logic [15:0] w);
    if (w[15] == 1'b0) return 2'd0;
    if (w[14] == 1'b0) return 2'd1;
    if (w[13] == 1'b0) return 2'd2;
    return 2'd3;
  endfunction

  function automatic bit ref_imm(input logic [15:0] w);
    case (ref_fmt(w))
      2'd0: return w[5:0] == 6'h10;
      2'd1: return (w[7:0] >= 8'h10) && (w[7:0] <= 8'h2e);
      2'd3: return w[12:8] == 5'd1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_push(input logic [15:0] w);
    return (ref_fmt(w) == 2'd2 && w[12]) || (ref_fmt(w) == 2'd3 && w[12:8] < 5'd2);
  endfunction

  function automatic int ref_cycles(input logic [15:0] w, input bit s);
    int c = 1;
    logic [1:0] f = ref_fmt(w);
    int op = w[14:10];
    if (ref_imm(w)) c += 1;
    if (f == 2'd0) begin
      if (op == 14 || op == 15) c += 1;
      if (op == 16 || op == 17) c += 31;
      if (op == 18 || op == 19) c += 15;
      if (op >= 22 && s) c += 1;
      if (op < 22 && w[9:6] == 4'd15) c += 1;
    end
    if (f == 2'd1) begin
      c += 1;
      if ((w[13:12] == 2'd0 || w[13:12] == 2'd2) && w[11:8] == 4'd15) c += 1;
    end
    if (f == 2'd2) c += 1 + (w[12] ? 1 : 0);
    if (f == 2'd3) begin
      if (w[12:8] < 5'd2) c += 2;
      else if (w[12:8] < 5'd4) c += 1;
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s instr=%h pc=%h skip=%0b: got %0d expected %0d", req, instr, pc, skip, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] p, input bit s);
    logic [15:0] tgt;
    @(posedge clk);
    instr = w; pc = p; skip = s;
    @(negedge clk);
    tgt = p + {{4{w[11]}}, w[11:0]};
    chk("R1 fmt", fmt, ref_fmt(w));
    chk("R2 imm", imm, ref_imm(w));
    chk("R2 len", len, ref_imm(w) ? 2 : 1);
    if (ref_fmt(w) == 2'd2) chk("R3 target", target, tgt);
    chk("R4 next_pc", next_pc, ref_fmt(w) == 2'd2 ? tgt : 16'(p + (ref_imm(w) ? 2 : 1)));
    chk("R5 push", push, ref_push(w));
    chk("R6-cost cycles", cycles, ref_cycles(w, s));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    instr = 16'h0000; pc = 16'h0000; skip = 1'b0;
    @(negedge clk);
    chk("R1 idle fmt", fmt, 0);
    chk("R6 idle cycles", cycles, 1);

    // R8 mov pc,imm = 3 ; R7 div pc,imm = 34 ; R8 ret = 3
    apply(16'h27D0, 16'h0100, 0); chk("R8 mov pc imm", cycles, 3);
    apply(16'h43D0, 16'h0100, 0); chk("R7 div pc imm", cycles, 34);
    apply(16'h8F2F, 16'h0100, 0); chk("R8 ret", cycles, 3);
    // R3 wrap backward and forward
    apply(16'hCFFF, 16'h0000, 0); chk("R3 wrap", target, 16'hFFFF);
    apply(16'hC7FF, 16'hFF00, 0); chk("R3 fwd wrap", target, 16'h06FF);
    apply(16'hD800, 16'h1000, 0); chk("R9 jsr rel cost", cycles, 3);
    // R5 misc jsr imm = 4
    apply(16'hE100, 16'h0200, 0); chk("R5 jsr imm", cycles, 4);
    // R2 mode boundaries
    apply(16'h800F, 16'h0, 0); chk("R2 m=0f", len, 1);
    apply(16'h8010, 16'h0, 0); chk("R2 m=10", len, 2);
    apply(16'h802E, 16'h0, 0); chk("R2 m=2e", len, 2);
    apply(16'h802F, 16'h0, 0); chk("R2 m=2f", len, 1);
    // R10 compare skip vs R10 skip ignored
    apply(16'h5801, 16'h0, 1); chk("R10 skip taken", cycles, 2);
    apply(16'h5801, 16'h0, 0); chk("R10 no skip", cycles, 1);
    apply(16'h0001, 16'h0, 1); chk("R10 skip ignored", cycles, 1);
    apply(16'h5BD0, 16'h0, 1); chk("R10 cmp r15 imm", cycles, 3);
    apply(16'h4A00, 16'h0, 0); chk("R7 mod", cycles, 16);
    apply(16'hE200, 16'h0, 0); chk("R9 lpw", cycles, 2);

    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule